// File: doc/BRIEF.md
# Suspend State Resume Controller

This block keeps track of the system power state: running, one of three suspend depths (clocks stopped with power held, memory kept alive alone, or everything off except the resume well), or fully unpowered. Each state maps to one fixed pattern on a group of active-low outputs. These outputs are a suspend-well reset, two suspend status lines and three suspend control lines (A, B, C). Software moves the block into a suspend depth through a request strobe that carries a target code.

Wake-up sources arrive as a vector of event lines, and each line has its own enable. Every line is synchronized and edge-detected. Each event is tied to the power well that holds its logic. Events from the resume well can wake the system from any suspend depth. Events from the main well can wake it only from the shallowest depth. The block accepts an event only when it is permitted and enabled. An accepted event sets a sticky status bit and returns the system to running in one step. Software clears status bits by writing ones.

Top module: `susp_resume_ctrl`

## Requirements
- R1: In the running state (state code 0) the reset output, both status outputs and all three control outputs are high, i.e. pins {rst,stat[1:0],ctl[2:0]} = 1,11,111, where ctl bit 0 is A, bit 1 is B and bit 2 is C.
- R2: In the shallow suspend (state code 1), reset is high, both status outputs are low and the control outputs are 110 (A low, B and C high).
- R3: In suspend-to-memory (state code 2), reset is high, both status outputs are low and the control outputs are 100 (only C high).
- R4: In the deep suspend/soft-off (state code 3), reset is high and every status and control output is low.
- R5: While the active-low resume-well reset is asserted, the state is unpowered (state code 4) at once, every output is low and all status bits are cleared. At the first clock edge after release, the state becomes soft-off.
- R6: A suspend request moves the state to its target on the next clock edge only when the state is running and the target code is 1, 2 or 3. Any other request is ignored.
- R7: Event bits 0 to 7 belong to the resume well. When enabled, each of them wakes the system from state code 1, 2 or 3.
- R8: Event bits 8 to 22 belong to the main well. They wake the system only from state code 1. In states 2 and 3 they change neither the state nor the status.
- R9: An event is ignored while running, while unpowered, or while its enable bit is low.
- R10: When an event line rises and the event is accepted, the matching status bit is set and the state becomes running on the third clock edge after the rise.
- R11: Status bits are sticky. A clear strobe clears the bits whose mask bits are one. A bit that is being set in the same cycle as a clear of that bit stays set.
- R12: Only a rising edge counts as an event. A line held high after it has woken the system cannot wake it again until it has gone low and risen again.
- R13: All events accepted in the same cycle set their status bits together in a single return to running. Events not permitted in that cycle stay unrecorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resume-well clock |
| rsm_rst_n | input | 1 | Active-low resume-well reset, asynchronous |
| sleep_req | input | 1 | Suspend request strobe |
| sleep_tgt | input | 3 | Target state code for the request |
| evt_in | input | 23 | Raw resume event lines |
| evt_en | input | 23 | Per-event enable |
| clr_strobe | input | 1 | Write-one-to-clear strobe for status |
| clr_mask | input | 23 | Status bits to clear |
| sus_rst_n | output | 1 | Suspend-well reset, active low |
| sus_stat_n | output | 2 | Suspend status lines, active low |
| sus_ctl_n | output | 3 | Suspend controls A (bit 0), B, C, active low |
| wake_sts | output | 23 | Sticky event status |
| pwr_state | output | 3 | Current state code |

## Verification
An accepted event and a status clear can land on the same clock edge. The bench first leaves one status bit set and puts the block into shallow suspend. It then raises a second event and asserts the clear strobe, with a mask that covers both bits, exactly one cycle before the acceptance edge. The result is judged as correct only if the older bit is gone and the new bit survives. A second collision is several events rising together in suspend-to-memory, where a main-well line is mixed with resume-well lines. That case must produce a single return to running with only the permitted bits recorded.

// File: rtl/pm_pkg.sv
package pm_pkg;

   typedef enum logic [2:0] {
      PS_ON   = 3'd0,
      PS_POS  = 3'd1,
      PS_STR  = 3'd2,
      PS_SOFF = 3'd3,
      PS_MOFF = 3'd4
   } pstate_t;

   typedef struct packed {
      logic       rst_n;
      logic [1:0] stat_n;
      logic [2:0] ctl_n;
   } pins_t;

   function automatic logic is_suspend(input pstate_t s);
      return (s == PS_POS) || (s == PS_STR) || (s == PS_SOFF);
   endfunction

   function automatic logic tgt_ok(input logic [2:0] t);
      return (t == 3'd1) || (t == 3'd2) || (t == 3'd3);
   endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
   parameter int WIDTH  = 23,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] rise_o
);
   localparam int LAST = STAGES - 1;

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              prev;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], raw_i[g]};
            prev  <= chain[LAST];
         end
      end

      assign rise_o[g] = chain[LAST] & ~prev;
   end

endmodule

// File: rtl/wake_filter.sv
module wake_filter
   import pm_pkg::*;
#(
   parameter int N_SUS  = 8,
   parameter int N_MAIN = 15
) (
   input  pstate_t                   state_i,
   input  logic [N_SUS+N_MAIN-1:0]   rise_i,
   input  logic [N_SUS+N_MAIN-1:0]   en_i,
   output logic [N_SUS+N_MAIN-1:0]   hit_o
);
   localparam int N = N_SUS + N_MAIN;

   logic deep_ok;
   logic shallow_ok;

   assign deep_ok    = is_suspend(state_i);
   assign shallow_ok = (state_i == PS_POS);

   for (genvar g = 0; g < N; g++) begin : g_evt
      if (g < N_SUS) begin : g_resume_well
         assign hit_o[g] = rise_i[g] & en_i[g] & deep_ok;
      end else begin : g_main_well
         assign hit_o[g] = rise_i[g] & en_i[g] & shallow_ok;
      end
   end

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
   import pm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req_i,
   input  logic [2:0] sleep_tgt_i,
   input  logic       wake_i,
   output pstate_t    state_o
);
   pstate_t cur, nxt;

   always_comb begin
      nxt = cur;
      unique case (cur)
         PS_ON:   if (sleep_req_i && tgt_ok(sleep_tgt_i)) nxt = pstate_t'(sleep_tgt_i);
         PS_POS,
         PS_STR,
         PS_SOFF: if (wake_i) nxt = PS_ON;
         PS_MOFF: nxt = PS_SOFF;
         default: nxt = PS_MOFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= PS_MOFF;
      else        cur <= nxt;
   end

   assign state_o = cur;

   assert_suspend_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      is_suspend(cur) |=> (cur == $past(cur)) || (cur == PS_ON));

   assert_moff_to_soff_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PS_MOFF) |=> (cur == PS_SOFF));

   assert_on_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PS_ON) |=> (cur == PS_ON) || (cur == pstate_t'($past(sleep_tgt_i))));

endmodule

// File: rtl/pin_decode.sv
module pin_decode
   import pm_pkg::*;
(
   input  pstate_t state_i,
   output pins_t   pins_o
);
   always_comb begin
      unique case (state_i)
         PS_ON:   pins_o = '{rst_n: 1'b1, stat_n: 2'b11, ctl_n: 3'b111};
         PS_POS:  pins_o = '{rst_n: 1'b1, stat_n: 2'b00, ctl_n: 3'b110};
         PS_STR:  pins_o = '{rst_n: 1'b1, stat_n: 2'b00, ctl_n: 3'b100};
         PS_SOFF: pins_o = '{rst_n: 1'b1, stat_n: 2'b00, ctl_n: 3'b000};
         default: pins_o = '{rst_n: 1'b0, stat_n: 2'b00, ctl_n: 3'b000};
      endcase
   end
endmodule

// File: rtl/wake_status.sv
module wake_status #(
   parameter int WIDTH = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] mask_i,
   output logic [WIDTH-1:0] sts_o
);
   logic [WIDTH-1:0] keep;

   assign keep = clr_i ? (sts_o & ~mask_i) : sts_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_o <= '0;
      else        sts_o <= keep | set_i;
   end

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && (set_i == '0)) |=> (sts_o == $past(sts_o)));

   assert_set_survives_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/susp_resume_ctrl.sv
module susp_resume_ctrl
   import pm_pkg::*;
#(
   parameter int N_SUS       = 8,
   parameter int N_MAIN      = 15,
   parameter int SYNC_STAGES = 2,
   localparam int N_EVT      = N_SUS + N_MAIN
) (
   input  logic             clk,
   input  logic             rsm_rst_n,
   input  logic             sleep_req,
   input  logic [2:0]       sleep_tgt,
   input  logic [N_EVT-1:0] evt_in,
   input  logic [N_EVT-1:0] evt_en,
   input  logic             clr_strobe,
   input  logic [N_EVT-1:0] clr_mask,
   output logic             sus_rst_n,
   output logic [1:0]       sus_stat_n,
   output logic [2:0]       sus_ctl_n,
   output logic [N_EVT-1:0] wake_sts,
   output logic [2:0]       pwr_state
);
   if (N_SUS < 1) begin : g_chk_sus
      $error("susp_resume_ctrl: N_SUS must be at least 1");
   end
   if (N_MAIN < 1) begin : g_chk_main
      $error("susp_resume_ctrl: N_MAIN must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("susp_resume_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [N_EVT-1:0] rise;
   logic [N_EVT-1:0] hit;
   logic             wake;
   pstate_t          state;
   pins_t            pins;

   evt_sync #(.WIDTH(N_EVT), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rsm_rst_n),
      .raw_i  (evt_in),
      .rise_o (rise)
   );

   wake_filter #(.N_SUS(N_SUS), .N_MAIN(N_MAIN)) u_filter (
      .state_i (state),
      .rise_i  (rise),
      .en_i    (evt_en),
      .hit_o   (hit)
   );

   assign wake = |hit;

   pm_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rsm_rst_n),
      .sleep_req_i (sleep_req),
      .sleep_tgt_i (sleep_tgt),
      .wake_i      (wake),
      .state_o     (state)
   );

   wake_status #(.WIDTH(N_EVT)) u_sts (
      .clk    (clk),
      .rst_n  (rsm_rst_n),
      .set_i  (hit),
      .clr_i  (clr_strobe),
      .mask_i (clr_mask),
      .sts_o  (wake_sts)
   );

   pin_decode u_dec (
      .state_i (state),
      .pins_o  (pins)
   );

   assign sus_rst_n  = pins.rst_n;
   assign sus_stat_n = pins.stat_n;
   assign sus_ctl_n  = pins.ctl_n;
   assign pwr_state  = state;

   assert_wake_to_on_R10: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      wake |=> (state == PS_ON) && ((wake_sts & $past(hit)) == $past(hit)));

   assert_main_blocked_R8: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      ((state == PS_STR) || (state == PS_SOFF)) |-> (hit[N_EVT-1:N_SUS] == '0));

   assert_idle_ignored_R9: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      ((state == PS_ON) || (state == PS_MOFF)) |-> (hit == '0));

   assert_hit_enabled_R9: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      ((hit & ~evt_en) == '0));

endmodule

// File: tb/susp_resume_ctrl_test.sv
module susp_resume_ctrl_test;
   localparam int N = 23;
   localparam int NS = 8;

   logic         clk = 1'b0;
   logic         rsm_rst_n = 1'b0;
   logic         sleep_req = 1'b0;
   logic [2:0]   sleep_tgt = 3'd0;
   logic [N-1:0] evt_in = '0;
   logic [N-1:0] evt_en = '1;
   logic         clr_strobe = 1'b0;
   logic [N-1:0] clr_mask = '0;
   logic         sus_rst_n;
   logic [1:0]   sus_stat_n;
   logic [2:0]   sus_ctl_n;
   logic [N-1:0] wake_sts;
   logic [2:0]   pwr_state;

   int errs = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   susp_resume_ctrl uut (
      .clk(clk), .rsm_rst_n(rsm_rst_n), .sleep_req(sleep_req), .sleep_tgt(sleep_tgt),
      .evt_in(evt_in), .evt_en(evt_en), .clr_strobe(clr_strobe), .clr_mask(clr_mask),
      .sus_rst_n(sus_rst_n), .sus_stat_n(sus_stat_n), .sus_ctl_n(sus_ctl_n),
      .wake_sts(wake_sts), .pwr_state(pwr_state)
   );

   // vector: tgt[8:6], idx[5:1], en[0]
   localparam logic [8:0] VEC [8] = '{
      {3'd1, 5'd0,  1'b1},
      {3'd2, 5'd3,  1'b1},
      {3'd3, 5'd7,  1'b1},
      {3'd1, 5'd8,  1'b1},
      {3'd2, 5'd12, 1'b1},
      {3'd3, 5'd22, 1'b1},
      {3'd2, 5'd5,  1'b0},
      {3'd1, 5'd15, 1'b0}
   };

   function automatic logic [5:0] exp_pins(input logic [2:0] s);
      case (s)
         3'd0: return 6'b1_11_111;
         3'd1: return 6'b1_00_110;
         3'd2: return 6'b1_00_100;
         3'd3: return 6'b1_00_000;
         default: return 6'b0;
      endcase
   endfunction

   function automatic string pin_req(input logic [2:0] s);
      case (s)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_pins(input logic [2:0] s);
      chk(pin_req(s), "pins", {sus_rst_n, sus_stat_n, sus_ctl_n}, exp_pins(s));
   endtask

   task automatic do_sleep(input logic [2:0] t);
      sleep_req = 1'b1; sleep_tgt = t;
      step(1);
      sleep_req = 1'b0; sleep_tgt = 3'd0;
   endtask

   task automatic clear_all;
      clr_strobe = 1'b1; clr_mask = '1;
      step(1);
      clr_strobe = 1'b0; clr_mask = '0;
   endtask

   // resume-well bit 1 used to return to running
   task automatic recover;
      evt_in[1] = 1'b1;
      step(3);
      chk("R7", "recover state", pwr_state, 0);
      evt_in[1] = 1'b0;
      step(3);
      clear_all();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL R10 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      step(2);
      chk("R5", "state in reset", pwr_state, 4);
      chk_pins(3'd4);
      chk("R5", "status in reset", wake_sts, 0);
      rsm_rst_n = 1'b1;
      step(1);
      chk("R5", "state after release", pwr_state, 3);
      chk_pins(3'd3);
      recover();
      chk_pins(3'd0);

      for (int i = 0; i < 8; i++) begin
         logic [2:0] t;
         int idx;
         logic en, exp_wake;
         t = VEC[i][8:6]; idx = int'(VEC[i][5:1]); en = VEC[i][0];
         exp_wake = en && ((idx < NS) || (t == 3'd1));
         evt_en = '1;
         evt_en[idx] = en;
         do_sleep(t);
         chk("R6", "sleep target", pwr_state, t);
         chk_pins(t);
         evt_in[idx] = 1'b1;
         step(3);
         chk(idx < NS ? "R7" : "R8", "state after event", pwr_state, exp_wake ? 0 : t);
         chk("R10", "status after event", wake_sts, exp_wake ? (longint'(1) << idx) : 0);
         evt_in[idx] = 1'b0;
         evt_en = '1;
         step(3);
         if (!exp_wake) recover();
         else clear_all();
      end

      // R6: invalid targets and request outside running
      do_sleep(3'd0);
      chk("R6", "target 0 ignored", pwr_state, 0);
      do_sleep(3'd5);
      chk("R6", "target 5 ignored", pwr_state, 0);
      do_sleep(3'd1);
      do_sleep(3'd2);
      chk("R6", "request in suspend ignored", pwr_state, 1);

      // R11: collision of set and clear; bit 0 stays sticky first
      evt_in[0] = 1'b1;
      step(3);
      evt_in[0] = 1'b0;
      step(4);
      chk("R11", "sticky bit", wake_sts, 1);
      do_sleep(3'd1);
      evt_in[2] = 1'b1;
      step(2);
      clr_strobe = 1'b1; clr_mask = 23'h5;
      step(1);
      clr_strobe = 1'b0; clr_mask = '0;
      chk("R11", "set beats clear", wake_sts, 23'h4);
      chk("R10", "collision wake", pwr_state, 0);
      evt_in[2] = 1'b0;
      step(3);
      clear_all();

      // R9: event while running
      evt_in[4] = 1'b1;
      step(4);
      chk("R9", "event in running status", wake_sts, 0);
      chk("R9", "event in running state", pwr_state, 0);
      evt_in[4] = 1'b0;
      step(3);

      // R12: held level does not rewake
      do_sleep(3'd1);
      evt_in[6] = 1'b1;
      step(3);
      chk("R12", "first wake", pwr_state, 0);
      clear_all();
      do_sleep(3'd2);
      step(5);
      chk("R12", "held level no rewake", pwr_state, 2);
      chk("R12", "held level no status", wake_sts, 0);
      evt_in[6] = 1'b0;
      step(3);
      evt_in[6] = 1'b1;
      step(3);
      chk("R12", "new edge wakes", pwr_state, 0);
      evt_in[6] = 1'b0;
      step(3);
      clear_all();

      // R13: simultaneous events in suspend-to-memory and shallow suspend
      do_sleep(3'd2);
      evt_in[2] = 1'b1; evt_in[5] = 1'b1; evt_in[10] = 1'b1;
      step(3);
      chk("R13", "mixed in STR status", wake_sts, 23'h24);
      chk("R13", "mixed in STR state", pwr_state, 0);
      evt_in = '0;
      step(3);
      clear_all();
      do_sleep(3'd1);
      evt_in[2] = 1'b1; evt_in[5] = 1'b1; evt_in[10] = 1'b1;
      step(3);
      chk("R13", "mixed in POS status", wake_sts, 23'h424);
      evt_in = '0;
      step(3);

      // R5: asynchronous reset mid-run
      @(negedge clk);
      #1 rsm_rst_n = 1'b0;
      #1;
      chk("R5", "async entry", pwr_state, 4);
      chk("R5", "status cleared", wake_sts, 0);
      chk_pins(3'd4);
      evt_in[0] = 1'b1;
      step(3);
      chk("R9", "event while unpowered", pwr_state, 4);
      evt_in[0] = 1'b0;
      step(3);
      rsm_rst_n = 1'b1;
      step(1);
      chk("R5", "release to soft-off", pwr_state, 3);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule